// File: doc/BRIEF.md
# Linked Command Table Walker

This block follows a chain of 32-byte command tables in a 16-bit command memory. A start strobe gives it the byte address of the first table. For each table it reads the control word. It then either stops, skips the table, aborts, or issues a one-cycle dispatch that carries a class code and the table's byte address. After that it moves to the next table according to a two-bit jump field. A single return slot supports one level of subroutine call.

The memory is a plain synchronous read port: an address issued with the read enable returns its word on the following cycle. A table whose jump field needs the link word costs a second read of the word two bytes into the table. To stop a corrupted chain from running forever, the walk ends by itself after a parameterised number of tables.

Top module: `cmdwalk_top`

## Requirements
- R1: A start pulse while idle loads the start address, clears the return slot, the abort flag and both pointer outputs, and raises busy on the next cycle. At the end of every walk, done is high for exactly one cycle, and busy is already low in that cycle.
- R2: A control word with bit 15 set ends the walk. That table is not dispatched, and the abort flag stays low.
- R3: Bits 3:0 give the command. Codes 0..7 dispatch class 0 (draw). Codes 8 and 11 dispatch class 1 (user clip). Code 9 dispatches class 2 (system clip). Code 10 dispatches class 3 (local coordinates). A dispatch is a one-cycle dispValid carrying dispClass and dispAddr, where dispAddr is the table's byte address. Dispatches appear in walk order.
- R4: A control word with bit 14 set and bit 15 clear is skipped. It is not dispatched and never aborts, even with an invalid code. Its jump field is still applied.
- R5: A non-skipped table with code 12..15 aborts the walk. Nothing is dispatched for it, the abort flag is set, both pointer outputs become the table byte address shifted right by 3, and done pulses.
- R6: Jump field bits 13:12 = 0 moves to the table address plus 0x20, wrapping modulo 2^ADDR_W.
- R7: Jump field = 1 moves to the link word, which sits at byte offset 2 in the table, multiplied by 8 and wrapped to ADDR_W bits.
- R8: Jump field = 2 moves to the link word times 8. When the return slot is empty it also stores the table address plus 0x20 there. When the slot is full, the held value is kept.
- R9: Jump field = 3 moves to the held return address and empties the slot. With an empty slot it acts as jump field 0.
- R10: After MAX_CMDS tables have been processed (dispatched or skipped), the walk ends with done and without abort, even when no end flag has been seen.
- R11: memRdEn is asserted only while busy, and each read returns its word one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, honoured only when idle |
| startAddr | input | ADDR_W | Byte address of the first table |
| memRdEn | output | 1 | Command memory read enable |
| memAddr | output | ADDR_W-1 | Command memory word address |
| memRdData | input | 16 | Word returned one cycle after the read |
| dispValid | output | 1 | One-cycle dispatch strobe |
| dispClass | output | 2 | Dispatched class code |
| dispAddr | output | ADDR_W | Byte address of the dispatched table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| aborted | output | 1 | Last walk ended on an invalid command |
| errLastPtr | output | ADDR_W-3 | Aborting table address >> 3 |
| errCurPtr | output | ADDR_W-3 | Aborting table address >> 3 |

## Verification
The chains used are:
- a straight run through every valid class code, which checks the class mapping;
- a skip-and-assign chain whose skipped table holds an invalid code, which separates skip from abort;
- a nested call with two returns, which shows whether a second call overwrites the slot and whether a return on an empty slot falls through;
- an abort after one good table;
- a table at the top of memory, which checks wrap-around;
- a return issued right after a fresh start, which shows whether start empties the slot;
- a self-linked table, which must stop at exactly the command cap.

A bench reference walker predicts every dispatch, and a scoreboard compares them in order.

// File: rtl/cmdwalk_pkg.sv
package cmdwalk_pkg;

  localparam int TBL_BYTES = 32;
  localparam int CTL_END   = 15;
  localparam int CTL_SKIP  = 14;

  typedef enum logic [1:0] {
    CLS_DRAW     = 2'd0,
    CLS_USERCLIP = 2'd1,
    CLS_SYSCLIP  = 2'd2,
    CLS_LOCAL    = 2'd3
  } cmdClass_e;

  typedef enum logic [1:0] {
    J_NEXT   = 2'd0,
    J_ASSIGN = 2'd1,
    J_CALL   = 2'd2,
    J_RETURN = 2'd3
  } jump_e;

  typedef struct packed {
    logic      valid;
    cmdClass_e cls;
  } cmdDecode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadStart;
    logic      rdCtrl;
    logic      rdLink;
    logic      emit;
    cmdClass_e cls;
    logic      stepNext;
    logic      stepReturn;
    logic      jumpLink;
    logic      saveReturn;
    logic      countUp;
    logic      latchAbort;
  } walkStrobe_t;

  function automatic cmdDecode_t decodeCmd(input logic [3:0] code);
    cmdDecode_t d;
    d.valid = 1'b1;
    d.cls   = CLS_DRAW;
    if (code[3]) begin
      case (code[2:0])
        3'd0, 3'd3: d.cls = CLS_USERCLIP;
        3'd1:       d.cls = CLS_SYSCLIP;
        3'd2:       d.cls = CLS_LOCAL;
        default:    d.valid = 1'b0;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/cmdwalk_ctrl.sv
module cmdwalk_ctrl
  import cmdwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] rdWord,
  input  logic        lastSlot,
  input  logic        capReached,
  output walkStrobe_t strb,
  output logic        busy,
  output logic        done
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DECODE, S_LINK} state_e;

  state_e     state, stateNext;
  logic       callQ, callNext;
  logic       finish;
  cmdDecode_t decoded;
  jump_e      jumpMode;

  always_comb begin
    strb      = '0;
    stateNext = state;
    callNext  = callQ;
    finish    = 1'b0;
    decoded   = decodeCmd(rdWord[3:0]);
    jumpMode  = jump_e'(rdWord[13:12]);
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.loadStart = 1'b1;
          stateNext      = S_FETCH;
        end
      end
      S_FETCH: begin
        strb.rdCtrl = 1'b1;
        stateNext   = S_DECODE;
      end
      S_DECODE: begin
        if (rdWord[CTL_END]) begin
          finish    = 1'b1;
          stateNext = S_IDLE;
        end else if (!rdWord[CTL_SKIP] && !decoded.valid) begin
          strb.latchAbort = 1'b1;
          finish          = 1'b1;
          stateNext       = S_IDLE;
        end else begin
          strb.countUp = 1'b1;
          strb.emit    = !rdWord[CTL_SKIP];
          strb.cls     = decoded.cls;
          case (jumpMode)
            J_NEXT:   strb.stepNext   = 1'b1;
            J_RETURN: strb.stepReturn = 1'b1;
            default: begin
              strb.rdLink = 1'b1;
              callNext    = (jumpMode == J_CALL);
            end
          endcase
          if (strb.rdLink) begin
            stateNext = S_LINK;
          end else if (lastSlot) begin
            finish    = 1'b1;
            stateNext = S_IDLE;
          end else begin
            stateNext = S_FETCH;
          end
        end
      end
      S_LINK: begin
        strb.jumpLink   = 1'b1;
        strb.saveReturn = callQ;
        if (capReached) begin
          finish    = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_FETCH;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      callQ <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      callQ <= callNext;
      done  <= finish;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/cmdwalk_dp.sv
module cmdwalk_dp
  import cmdwalk_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int MAX_CMDS = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [15:0]       memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-2:0] memAddr,
  output logic              lastSlot,
  output logic              capReached,
  output logic              dispValid,
  output logic [1:0]        dispClass,
  output logic [ADDR_W-1:0] dispAddr,
  output logic              aborted,
  output logic [ADDR_W-4:0] errLastPtr,
  output logic [ADDR_W-4:0] errCurPtr
);

  localparam int CNT_W = $clog2(MAX_CMDS + 1);

  logic [ADDR_W-1:0] tblAddr, retAddr, stepAddr, linkTarget, linkByte;
  logic              retValid;
  logic [CNT_W-1:0]  cmdCnt;

  assign stepAddr   = tblAddr + ADDR_W'(TBL_BYTES);
  assign linkByte   = tblAddr + ADDR_W'(2);
  assign linkTarget = ADDR_W'({memRdData, 3'b000});

  assign memRdEn    = strb.rdCtrl | strb.rdLink;
  assign memAddr    = strb.rdLink ? linkByte[ADDR_W-1:1] : tblAddr[ADDR_W-1:1];
  assign lastSlot   = (cmdCnt == CNT_W'(MAX_CMDS - 1));
  assign capReached = (cmdCnt == CNT_W'(MAX_CMDS));

  // Walk pointer, return slot and command counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tblAddr  <= '0;
      retAddr  <= '0;
      retValid <= 1'b0;
      cmdCnt   <= '0;
    end else begin
      if (strb.loadStart) begin
        tblAddr  <= startAddr;
        retValid <= 1'b0;
        cmdCnt   <= '0;
      end
      if (strb.countUp) cmdCnt <= cmdCnt + CNT_W'(1);
      if (strb.stepNext) tblAddr <= stepAddr;
      if (strb.stepReturn) begin
        if (retValid) begin
          tblAddr  <= retAddr;
          retValid <= 1'b0;
        end else begin
          tblAddr <= stepAddr;
        end
      end
      if (strb.jumpLink) begin
        tblAddr <= linkTarget;
        if (strb.saveReturn && !retValid) begin
          retAddr  <= stepAddr;
          retValid <= 1'b1;
        end
      end
    end
  end

  // Dispatch and abort status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispValid  <= 1'b0;
      dispClass  <= '0;
      dispAddr   <= '0;
      aborted    <= 1'b0;
      errLastPtr <= '0;
      errCurPtr  <= '0;
    end else begin
      dispValid <= strb.emit;
      if (strb.emit) begin
        dispClass <= strb.cls;
        dispAddr  <= tblAddr;
      end
      if (strb.loadStart) begin
        aborted    <= 1'b0;
        errLastPtr <= '0;
        errCurPtr  <= '0;
      end
      if (strb.latchAbort) begin
        aborted    <= 1'b1;
        errLastPtr <= tblAddr[ADDR_W-1:3];
        errCurPtr  <= tblAddr[ADDR_W-1:3];
      end
    end
  end

endmodule

// File: rtl/cmdwalk_top.sv
module cmdwalk_top
  import cmdwalk_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int MAX_CMDS = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memRdEn,
  output logic [ADDR_W-2:0] memAddr,
  input  logic [15:0]       memRdData,
  output logic              dispValid,
  output logic [1:0]        dispClass,
  output logic [ADDR_W-1:0] dispAddr,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic [ADDR_W-4:0] errLastPtr,
  output logic [ADDR_W-4:0] errCurPtr
);

  walkStrobe_t strb;
  logic        lastSlot, capReached;

  cmdwalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdWord(memRdData),
    .lastSlot(lastSlot), .capReached(capReached),
    .strb(strb), .busy(busy), .done(done)
  );

  cmdwalk_dp #(.ADDR_W(ADDR_W), .MAX_CMDS(MAX_CMDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .memRdData(memRdData), .memRdEn(memRdEn), .memAddr(memAddr),
    .lastSlot(lastSlot), .capReached(capReached),
    .dispValid(dispValid), .dispClass(dispClass), .dispAddr(dispAddr),
    .aborted(aborted), .errLastPtr(errLastPtr), .errCurPtr(errCurPtr)
  );

endmodule

// File: rtl/cmdwalk_chk.sv
module cmdwalk_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic dispValid,
  input logic aborted,
  input logic memRdEn
);

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  abort_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aborted) |-> done);

  // R5
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    aborted |-> !dispValid);

  // R11
  read_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

endmodule

bind cmdwalk_top cmdwalk_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .dispValid(dispValid), .aborted(aborted), .memRdEn(memRdEn)
);

// File: tb/sim_cmdwalk_top.sv
module sim_cmdwalk_top;

  localparam int AW   = 12;
  localparam int MAXC = 2000;
  localparam int WORDS = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          memRdEn;
  logic [AW-2:0] memAddr;
  logic [15:0]   memRdData = '0;
  logic          dispValid;
  logic [1:0]    dispClass;
  logic [AW-1:0] dispAddr;
  logic          busy, done, aborted;
  logic [AW-4:0] errLastPtr, errCurPtr;

  logic [15:0]   mem [0:WORDS-1];
  logic [13:0]   expQ [$];
  int            nChecks = 0;
  int            nFails  = 0;
  string         curTag  = "R3";

  cmdwalk_top #(.ADDR_W(AW), .MAX_CMDS(MAXC)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .dispValid(dispValid), .dispClass(dispClass), .dispAddr(dispAddr),
    .busy(busy), .done(done), .aborted(aborted),
    .errLastPtr(errLastPtr), .errCurPtr(errCurPtr)
  );

  always #10 clk = ~clk;

  // Synchronous memory model, one cycle read latency (R11)
  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (dispValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, curTag, "unexpected dispatch", {dispClass, dispAddr}, 0);
      end else begin
        logic [13:0] e;
        e = expQ.pop_front();
        check({dispClass, dispAddr} == e, curTag, "dispatch class/addr",
              {dispClass, dispAddr}, e);
      end
    end
  end

  function automatic logic [15:0] mk(input bit fin, input bit skip,
                                     input int mode, input int code);
    return {fin, skip, 2'(mode), 8'h00, 4'(code)};
  endfunction

  task automatic clearMem();
    for (int i = 0; i < WORDS; i++) mem[i] = 16'h8000;
  endtask

  task automatic putTable(input int a, input logic [15:0] ctl, input int link);
    mem[(a >> 1) % WORDS]       = ctl;
    mem[((a >> 1) + 1) % WORDS] = 16'(link);
  endtask

  // Reference walker written from the requirements
  task automatic refWalk(input int sa, output bit expAb, output int expPtr);
    int a = sa;
    int ra = 0;
    bit rv = 0;
    int n = 0;
    logic [15:0] w;
    logic [15:0] lk;
    int code;
    int cls;
    expAb = 0;
    expPtr = 0;
    while (n < MAXC) begin
      w = mem[(a >> 1) % WORDS];
      if (w[15]) break;
      if (!w[14]) begin
        code = int'(w[3:0]);
        if (code > 11) begin
          expAb = 1;
          expPtr = a >> 3;
          break;
        end
        if (code < 8) cls = 0;
        else if (code == 8 || code == 11) cls = 1;
        else if (code == 9) cls = 2;
        else cls = 3;
        expQ.push_back({2'(cls), 12'(a)});
      end
      lk = mem[((a >> 1) + 1) % WORDS];
      case (w[13:12])
        2'd0: a = a + 32;
        2'd1: a = int'(lk) * 8;
        2'd2: begin
          if (!rv) begin ra = (a + 32) % 4096; rv = 1; end
          a = int'(lk) * 8;
        end
        default: begin
          if (rv) begin a = ra; rv = 0; end
          else a = a + 32;
        end
      endcase
      a = a % 4096;
      n++;
    end
  endtask

  task automatic runWalk(input int sa, input string tag);
    bit ea;
    int ep;
    int cyc;
    curTag = tag;
    refWalk(sa, ea, ep);
    @(negedge clk);
    start = 1'b1;
    startAddr = AW'(sa);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc < 20000, tag, "walk ended", cyc, 0);
    check(busy == 1'b0, "R1", "busy low with done", busy, 0);
    check(aborted == ea, tag, "abort flag", aborted, ea);
    if (ea) begin
      check(int'(errLastPtr) == ep, "R5", "last pointer", errLastPtr, ep);
      check(int'(errCurPtr) == ep, "R5", "current pointer", errCurPtr, ep);
    end
    @(negedge clk);
    check(done == 1'b0, "R1", "done is one cycle", done, 0);
    check(expQ.size() == 0, tag, "dispatches left over", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    #(190000 * 20);
    nFails++;
    $display("FAIL R1 watchdog expired: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && dispValid == 0 && aborted == 0, "R1",
          "reset state", {busy, done, dispValid, aborted}, 0);
    check(memRdEn == 0, "R11", "no read while idle", memRdEn, 0);

    // R2 R3 R6: every valid class in a straight run
    putTable(12'h100, mk(0, 0, 0, 0), 0);
    putTable(12'h120, mk(0, 0, 0, 8), 0);
    putTable(12'h140, mk(0, 0, 0, 9), 0);
    putTable(12'h160, mk(0, 0, 0, 10), 0);
    putTable(12'h180, mk(0, 0, 0, 11), 0);
    putTable(12'h1A0, mk(0, 0, 0, 5), 0);
    putTable(12'h1C0, mk(1, 0, 0, 0), 0);
    runWalk(12'h100, "R3");

    // R4 R7: skip with invalid code, assign jumps
    clearMem();
    putTable(12'h200, mk(0, 1, 1, 13), 12'h300 >> 3);
    putTable(12'h300, mk(0, 0, 1, 2), 12'h400 >> 3);
    putTable(12'h400, mk(0, 1, 0, 0), 0);
    runWalk(12'h200, "R4");
    check(aborted == 0, "R7", "skip chain not aborted", aborted, 0);

    // R8 R9: nested call keeps first slot, empty return falls through
    clearMem();
    putTable(12'h500, mk(0, 0, 2, 1), 12'h600 >> 3);
    putTable(12'h600, mk(0, 0, 2, 9), 12'h700 >> 3);
    putTable(12'h700, mk(0, 0, 3, 10), 0);
    putTable(12'h520, mk(0, 0, 3, 8), 0);
    runWalk(12'h500, "R8");

    // R5: abort after one good table
    clearMem();
    putTable(12'h800, mk(0, 0, 0, 3), 0);
    putTable(12'h820, mk(0, 0, 0, 14), 0);
    runWalk(12'h800, "R5");

    // R6: wrap from top of memory; start clears abort flag (R1)
    clearMem();
    putTable(12'hFE0, mk(0, 0, 0, 4), 0);
    runWalk(12'hFE0, "R6");

    // R1 R9: start empties the return slot
    clearMem();
    putTable(12'h900, mk(0, 0, 2, 0), 12'hA00 >> 3);
    putTable(12'h920, mk(0, 0, 0, 7), 0);
    runWalk(12'h900, "R9");
    putTable(12'hB00, mk(0, 0, 3, 0), 0);
    runWalk(12'hB00, "R1");

    // R10: self-linked table hits the command cap
    clearMem();
    putTable(12'h000, mk(0, 0, 1, 0), 0);
    runWalk(12'h000, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule